// File: doc/BRIEF.md
# Multi-cycle register-file microprocessor

This block is a small processor built as a controller and a datapath. It holds sixteen 16-bit general registers, a program counter, an instruction register and one adder/subtractor. It fetches 16-bit instructions from an external single-ported word memory and runs each instruction over several clock cycles. Every instruction passes through three states: a fetch state, a decode state that picks the operation, and one execute state that then returns to fetch.

An instruction word holds the opcode in bits [15:12] and the target register Rn in bits [11:8]. Bits [7:0] hold the operand: a memory address, an unsigned immediate, or a signed relative offset. For register-to-register forms, the second register Rm is in bits [7:4]. The memory must return read data combinationally in the same cycle as the address. A write takes effect at the clock edge that ends the cycle in which the write enable is high.

Top module: `mcyc_cpu`

## Requirements
- R1: While reset is held and in the first cycle after it, the block fetches from address 0: mem_addr is 0, mem_re is 1 and mem_we is 0. All sixteen registers read zero after reset.
- R2: Each defined instruction takes exactly three cycles. The fetch cycle reads M[PC] with mem_re high and advances PC by one. A decode cycle and an execute cycle follow, and the next fetch comes right after them.
- R3: Opcode 0011 writes Rn with the 8-bit operand zero-extended to 16 bits.
- R4: Opcode 0000 writes Rn with M[operand], where the operand is taken as an 8-bit address.
- R5: Opcode 0001 writes Rn to M[operand].
- R6: Opcode 0010 writes Rm (bits [7:4]) to the memory address given by the low 8 bits of Rn.
- R7: Opcode 0100 sets Rn to Rn+Rm, and opcode 0101 sets Rn to Rn−Rm. Both results wrap modulo 2^16, and Rm is unchanged when it differs from Rn.
- R8: Opcode 0110 tests Rn. If Rn is zero, PC becomes the address after the jump plus the sign-extended 8-bit operand, wrapping modulo 256. Otherwise execution continues at the next word.
- R9: Opcodes 0111 to 1111 change no register and write no memory. They take two cycles and then fetch the next word.
- R10: A countdown loop that adds 10 down to 1, built from these instructions, leaves 55 in its accumulator register.
- R11: mem_we is high only in the execute cycle of opcodes 0001 and 0010, and never in the same cycle as mem_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Word address to memory |
| mem_wdata | output | 16 | Data to be written |
| mem_rdata | input | 16 | Combinational read data for mem_addr |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |

## Verification
The assertions assume that reset is held for at least one clock edge and that mem_rdata is a settled function of mem_addr within the cycle. The bench's memory model returns array contents combinationally and commits writes on the rising edge, so both conditions hold. Every program in the bench ends in a jump-to-self on register 15. Register 15 is never written, so the processor stays in a known loop instead of running into memory that was never loaded. The random operands come from 16-bit memory loads, so the adds and subtracts cover carry, borrow and zero results.

// File: rtl/mcyc_cpu.sv
module mcyc_cpu #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re
);
  localparam int NREG = 16;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_LD, S_ST, S_STI, S_LI, S_ADD, S_SUB, S_JZ
  } state_t;

  state_t          state;
  logic [AW-1:0]   pc;
  logic [15:0]     ir;
  logic [DW-1:0]   rf [NREG];
  logic [DW-1:0]   rd_n, rd_m, alu_y, wr_data;
  logic            rf_we, alu_zero;

  wire [3:0] op  = ir[15:12];
  wire [3:0] rn  = ir[11:8];
  wire [3:0] rm  = ir[7:4];
  wire [7:0] opd = ir[7:0];

  assign rd_n     = rf[rn];
  assign rd_m     = rf[rm];
  assign alu_y    = (state == S_SUB) ? rd_n - rd_m : rd_n + rd_m;
  assign alu_zero = (rd_n == '0);

  always_comb begin
    unique case (state)
      S_FETCH:      mem_addr = pc;
      S_LD, S_ST:   mem_addr = AW'(opd);
      S_STI:        mem_addr = rd_n[AW-1:0];
      default:      mem_addr = '0;
    endcase
  end

  assign mem_re    = (state == S_FETCH) || (state == S_LD);
  assign mem_we    = (state == S_ST) || (state == S_STI);
  assign mem_wdata = (state == S_STI) ? rd_m : rd_n;

  assign rf_we = (state == S_LD) || (state == S_LI) ||
                 (state == S_ADD) || (state == S_SUB);

  always_comb begin
    unique case (state)
      S_LD:    wr_data = mem_rdata;
      S_LI:    wr_data = DW'(opd);
      default: wr_data = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      unique case (state)
        S_FETCH: begin
          ir    <= mem_rdata[15:0];
          pc    <= pc + 1'b1;
          state <= S_DECODE;
        end
        S_DECODE: begin
          unique case (op)
            4'b0000: state <= S_LD;
            4'b0001: state <= S_ST;
            4'b0010: state <= S_STI;
            4'b0011: state <= S_LI;
            4'b0100: state <= S_ADD;
            4'b0101: state <= S_SUB;
            4'b0110: state <= S_JZ;
            default: state <= S_FETCH;
          endcase
        end
        S_JZ: begin
          if (alu_zero) pc <= pc + AW'($signed(opd));
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[rn] <= wr_data;
    end
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> (state == S_DECODE) && (pc == $past(pc) + 1'b1));

  assert_exec_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_FETCH && state != S_DECODE) |=> (state == S_FETCH));

  assert_jz_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_JZ && rd_n != '0) |=> (pc == $past(pc)));

  assert_undef_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE && op > 4'b0110) |=> (state == S_FETCH) && $stable(pc));

  assert_we_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_re);

  assert_we_after_decode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(state) == S_DECODE);
endmodule

// File: tb/mcyc_cpu_bench.sv
`timescale 1ns/1ps
module mcyc_cpu_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, mem_re;
  logic [15:0] mem [256];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  mcyc_cpu u_mcyc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  localparam logic [15:0] HALT = 16'h6FFF;

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] rn, input logic [7:0] o);
    return {op, rn, o};
  endfunction
  function automatic logic [15:0] alu_ref(input bit sub, input logic [15:0] x, input logic [15:0] y);
    return sub ? x - y : x + y;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic start();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst_n = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));

    // R1, R2: reset state and three-cycle sequence
    hold_reset();
    clear_mem();
    mem[0] = enc(4'h3, 4'h1, 8'h05);
    mem[1] = HALT;
    @(negedge clk);
    chk("R1 addr in reset", {8'h0, mem_addr}, 16'h0);
    chk("R1 re in reset", {15'h0, mem_re}, 16'h1);
    chk("R1 we in reset", {15'h0, mem_we}, 16'h0);
    rst_n = 1;
    chk("R1 first fetch addr", {8'h0, mem_addr}, 16'h0);
    @(negedge clk);
    chk("R2 decode no read", {15'h0, mem_re}, 16'h0);
    @(negedge clk);
    chk("R2 exec no read", {15'h0, mem_re}, 16'h0);
    @(negedge clk);
    chk("R2 next fetch addr", {8'h0, mem_addr}, 16'h1);
    chk("R2 next fetch re", {15'h0, mem_re}, 16'h1);

    // R1: registers zero after reset (store R9 untouched)
    hold_reset(); clear_mem();
    mem[0] = enc(4'h1, 4'h9, 8'hE0);
    mem[1] = HALT;
    mem[8'hE0] = 16'hBEEF;
    start(); repeat (20) @(negedge clk);
    chk("R1 register cleared", mem[8'hE0], 16'h0000);

    // R3, R5, R6, R11: immediate, direct store, indirect store
    hold_reset(); clear_mem();
    mem[0] = enc(4'h3, 4'h4, 8'hC5);
    mem[1] = enc(4'h3, 4'h5, 8'h9A);
    mem[2] = enc(4'h2, 4'h4, 8'h50);
    mem[3] = enc(4'h1, 4'h4, 8'hD0);
    mem[4] = HALT;
    start(); repeat (30) @(negedge clk);
    chk("R6 indirect store", mem[8'hC5], 16'h009A);
    chk("R3 zero-extended immediate", mem[8'hD0], 16'h00C5);
    chk("R11 no stray write", mem[8'h9A], 16'h0000);

    // R9: undefined opcodes
    hold_reset(); clear_mem();
    mem[0] = enc(4'h3, 4'h6, 8'h11);
    mem[1] = enc(4'h7, 4'h6, 8'h66);
    mem[2] = enc(4'hF, 4'h6, 8'hFF);
    mem[3] = enc(4'h1, 4'h6, 8'hD1);
    mem[4] = HALT;
    mem[8'hFF] = 16'h1234;
    mem[8'h66] = 16'h4321;
    start();
    repeat (3) @(negedge clk);   // LI done, now fetch of word 1
    chk("R9 fetch undefined", {8'h0, mem_addr}, 16'h1);
    repeat (2) @(negedge clk);   // undefined takes two cycles
    chk("R9 two-cycle skip", {8'h0, mem_addr}, 16'h2);
    repeat (30) @(negedge clk);
    chk("R9 register unchanged", mem[8'hD1], 16'h0011);
    chk("R9 no memory write FF", mem[8'hFF], 16'h1234);
    chk("R9 no memory write 66", mem[8'h66], 16'h4321);

    // R8: jump not taken, then taken forward
    hold_reset(); clear_mem();
    mem[0] = enc(4'h3, 4'h7, 8'h01);
    mem[1] = enc(4'h6, 4'h7, 8'h01);
    mem[2] = enc(4'h3, 4'h8, 8'h22);
    mem[3] = enc(4'h6, 4'hF, 8'h01);
    mem[4] = enc(4'h3, 4'h8, 8'h33);
    mem[5] = enc(4'h1, 4'h8, 8'hD2);
    mem[6] = HALT;
    start(); repeat (40) @(negedge clk);
    chk("R8 not-taken then taken", mem[8'hD2], 16'h0022);

    // R8: backward wrap past address 0
    hold_reset(); clear_mem();
    mem[0]     = enc(4'h6, 4'hF, 8'hF0);
    mem[8'hF1] = enc(4'h3, 4'h2, 8'h77);
    mem[8'hF2] = enc(4'h1, 4'h2, 8'hD3);
    mem[8'hF3] = HALT;
    start(); repeat (30) @(negedge clk);
    chk("R8 wrap target", mem[8'hD3], 16'h0077);

    // R4, R5, R7: random ALU trials
    for (int t = 0; t < 40; t++) begin
      logic [3:0] a, b;
      logic [15:0] x, y;
      bit sub;
      a = 4'($urandom_range(0, 14));
      b = 4'($urandom_range(0, 13));
      if (b >= a) b = b + 1;
      x = 16'($urandom);
      y = (t % 8 == 3) ? x : 16'($urandom);
      if (t == 0) begin x = 16'hFFFF; y = 16'h0001; end
      sub = bit'(t % 2);
      hold_reset(); clear_mem();
      mem[8'hA0] = x; mem[8'hA1] = y;
      mem[0] = enc(4'h0, a, 8'hA0);
      mem[1] = enc(4'h0, b, 8'hA1);
      mem[2] = enc(sub ? 4'h5 : 4'h4, a, {b, 4'h0});
      mem[3] = enc(4'h1, a, 8'hB0);
      mem[4] = enc(4'h1, b, 8'hB1);
      mem[5] = HALT;
      start(); repeat (24) @(negedge clk);
      chk(sub ? "R7 subtract" : "R7 add", mem[8'hB0], alu_ref(sub, x, y));
      chk("R4 R5 load then store", mem[8'hB1], y);
    end

    // R10: sum of 10 down to 1
    hold_reset(); clear_mem();
    mem[0] = enc(4'h3, 4'h0, 8'h00);
    mem[1] = enc(4'h3, 4'h1, 8'h0A);
    mem[2] = enc(4'h3, 4'h2, 8'h01);
    mem[3] = enc(4'h3, 4'h3, 8'h00);
    mem[4] = enc(4'h6, 4'h1, 8'h03);
    mem[5] = enc(4'h4, 4'h0, 8'h10);
    mem[6] = enc(4'h5, 4'h1, 8'h20);
    mem[7] = enc(4'h6, 4'h3, 8'hFC);
    mem[8] = enc(4'h1, 4'h0, 8'h80);
    mem[9] = enc(4'h1, 4'h1, 8'h81);
    mem[10] = HALT;
    start(); repeat (200) @(negedge clk);
    chk("R10 loop sum", mem[8'h80], 16'd55);
    chk("R10 counter ends at zero", mem[8'h81], 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule